// File: doc/BRIEF.md
# Stacked SCSI Interrupt Status Unit

This unit gathers interrupt conditions from the SCSI side of a bus controller into two status registers. Each has an enable register beside it, and the unit drives one interrupt request line. Bank zero holds eight conditions. Bank one holds three timer conditions: selection timeout, general timer expiry and handshake timer expiry. Most conditions arrive as one-cycle event pulses. The phase-mismatch/attention condition is detected inside the unit, from the bus REQ, ATN and phase signals.

Every status bit has one stacked level behind it, called the pending level. An event for a bit that is already recorded is parked in the pending level, so it is not lost. A status read returns the register and clears only the bits that were set at that moment. The unit then stays busy for a fixed number of cycles. At the end of the busy period, parked events move forward into the status bits that the read emptied. One read therefore does not always leave a register clear. Software polls the register until it reads zero.

Top module: `scsi_irq_stack`

## Requirements
- R1: After reset, both status registers, both pending levels, both enable registers, `rdata_o`, `irq_o` and `busy_o` are all 0.
- R2: Status register zero (address 0) holds these bits, from 7 down to 0: phase mismatch/attention, function complete, selected, reselected, gross error, unexpected disconnect, bus reset, parity error. `evt0_i[k]` (k=0..6) sets bit k on the clock edge where the pulse is high. A read returns every recorded bit, whatever the enables are.
- R3: Status register one (address 1) holds selection timeout in bit 2, general timer in bit 1 and handshake timer in bit 0, set by `evt1_i[2:0]`. Bits 7..3 of status one, and of enable one (address 3), always read as 0.
- R4: A status read, with `rd_en_i` high while `busy_o` is low, places the pre-read register value on `rdata_o` one cycle later. It clears exactly the bits that were set at that edge, and only in the register addressed.
- R5: An event for a bit whose status is already set goes to that bit's pending level. The pending level holds one event; further events merge into it. Pending bits move into status on the last cycle of the busy period that follows the read which cleared them.
- R6: An event that arrives in the same cycle as the read that clears its bit is placed in the pending level. It shows in status only after the busy period.
- R7: Each accepted status read holds `busy_o` high for exactly BUSY_CYCLES (default 12) cycles. A status read made while busy is ignored: `rdata_o` keeps its value and nothing is cleared.
- R8: `irq_o` is high exactly when some status bit and its matching enable bit are both set. Enable registers reset to 0, and a cleared enable bit masks its condition.
- R9: Writes to the status addresses (0 and 1) have no effect. Enable zero (address 2) stores all 8 bits; enable one stores bits 2..0.
- R10: In initiator mode (`target_mode_i`=0), a rising `req_i` sets status bit 7 when `bus_phase_i` differs from `exp_phase_i`, and leaves it clear when they match. In target mode, a rising `atn_i` sets bit 7, and `req_i` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt0_i | input | 7 | Event pulses for status zero bits 6..0 |
| evt1_i | input | 3 | Event pulses for status one bits 2..0 |
| target_mode_i | input | 1 | 1 = target mode, 0 = initiator mode |
| req_i | input | 1 | Bus REQ level |
| atn_i | input | 1 | Bus ATN level |
| bus_phase_i | input | 3 | Phase currently driven on the bus |
| exp_phase_i | input | 3 | Phase the current instruction expects |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status0, 1 status1, 2 enable0, 3 enable1 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| busy_o | output | 1 | Post-read settle period in progress |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. An accepted status read clears the bits it saw and starts the busy period. A read made while busy leaves the read data untouched. An event that hits a set bit always lands in the pending level. Outside a busy period, no pending bit sits behind an empty status bit, and the request line stays low when both status registers are empty. The bench scenarios cover the rest: bit order and mapping, the exact busy length, promotion after the busy period, merging of repeated events, masking of each bit by each enable bit, and the phase-compare rules in both bus modes.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
    localparam int DATA_W  = 8;
    localparam int ST0_W   = 8;
    localparam int ST1_W   = 3;
    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        SEL_ST0 = 2'd0,
        SEL_ST1 = 2'd1,
        SEL_EN0 = 2'd2,
        SEL_EN1 = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_phase_event.sv
module irq_phase_event #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          target_mode_i,
    input  logic          req_i,
    input  logic          atn_i,
    input  logic [PW-1:0] bus_phase_i,
    input  logic [PW-1:0] exp_phase_i,
    output logic          ev_o
);
    typedef struct packed {
        logic req;
        logic atn;
    } edge_t;

    edge_t edge_d, edge_q;
    logic  req_rise, atn_rise, mismatch;

    always_comb begin
        edge_d.req = req_i;
        edge_d.atn = atn_i;
        req_rise   = req_i & ~edge_q.req;
        atn_rise   = atn_i & ~edge_q.atn;
        mismatch   = (bus_phase_i != exp_phase_i);
        if (target_mode_i) begin
            ev_o = atn_rise;
        end else begin
            ev_o = req_rise & mismatch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end
endmodule

// File: rtl/irq_busy_timer.sv
module irq_busy_timer #(
    parameter int CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
        busy_o = (cnt_q != '0);
        last_o = (cnt_q == ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    input  logic         clr_i,
    input  logic         promote_i,
    output logic [W-1:0] stat_o,
    output logic [W-1:0] pend_o
);
    typedef struct packed {
        logic [W-1:0] stat;
        logic [W-1:0] pend;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [W-1:0] clr_mask, promo, occupied, to_stat, to_pend;

    always_comb begin
        clr_mask = clr_i ? bank_q.stat : '0;
        promo    = promote_i ? (bank_q.pend & ~bank_q.stat) : '0;
        occupied = bank_q.stat | promo;
        to_stat  = ev_i & ~occupied;
        to_pend  = ev_i & occupied;
        bank_d.stat = (bank_q.stat & ~clr_mask) | promo | to_stat;
        bank_d.pend = (bank_q.pend & ~promo) | to_pend;
        stat_o = bank_q.stat;
        pend_o = bank_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end
endmodule

// File: rtl/scsi_irq_stack.sv
module scsi_irq_stack
    import scsi_irq_pkg::*;
#(
    parameter int BUSY_CYCLES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ST0_W-2:0]   evt0_i,
    input  logic [ST1_W-1:0]   evt1_i,
    input  logic               target_mode_i,
    input  logic               req_i,
    input  logic               atn_i,
    input  logic [PHASE_W-1:0] bus_phase_i,
    input  logic [PHASE_W-1:0] exp_phase_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [1:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               busy_o,
    output logic               irq_o
);
    localparam int PAD1 = DATA_W - ST1_W;

    typedef struct packed {
        logic [ST0_W-1:0]  en0;
        logic [ST1_W-1:0]  en1;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             mm_ev;
    logic [ST0_W-1:0] ev0;
    logic [ST0_W-1:0] stat0_w, pend0_w;
    logic [ST1_W-1:0] stat1_w, pend1_w;
    logic             rd_st0, rd_st1, start_busy, busy_w, last_w;
    reg_sel_e         sel;

    irq_phase_event #(.PW(PHASE_W)) phase_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .target_mode_i (target_mode_i),
        .req_i         (req_i),
        .atn_i         (atn_i),
        .bus_phase_i   (bus_phase_i),
        .exp_phase_i   (exp_phase_i),
        .ev_o          (mm_ev)
    );

    assign ev0 = {mm_ev, evt0_i};

    irq_status_bank #(.W(ST0_W)) bank0_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev0),
        .clr_i     (rd_st0),
        .promote_i (last_w),
        .stat_o    (stat0_w),
        .pend_o    (pend0_w)
    );

    irq_status_bank #(.W(ST1_W)) bank1_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (evt1_i),
        .clr_i     (rd_st1),
        .promote_i (last_w),
        .stat_o    (stat1_w),
        .pend_o    (pend1_w)
    );

    irq_busy_timer #(.CYCLES(BUSY_CYCLES)) busy_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_busy),
        .busy_o  (busy_w),
        .last_o  (last_w)
    );

    always_comb begin
        sel        = reg_sel_e'(addr_i);
        rd_st0     = rd_en_i && !busy_w && (sel == SEL_ST0);
        rd_st1     = rd_en_i && !busy_w && (sel == SEL_ST1);
        start_busy = rd_st0 || rd_st1;
        regs_d     = regs_q;
        if (rd_en_i) begin
            case (sel)
                SEL_ST0: if (!busy_w) regs_d.rdata = stat0_w;
                SEL_ST1: if (!busy_w) regs_d.rdata = {{PAD1{1'b0}}, stat1_w};
                SEL_EN0: regs_d.rdata = regs_q.en0;
                default: regs_d.rdata = {{PAD1{1'b0}}, regs_q.en1};
            endcase
        end
        if (wr_en_i) begin
            case (sel)
                SEL_EN0: regs_d.en0 = wdata_i;
                SEL_EN1: regs_d.en1 = wdata_i[ST1_W-1:0];
                default: ;
            endcase
        end
        rdata_o = regs_q.rdata;
        busy_o  = busy_w;
        irq_o   = (|(stat0_w & regs_q.en0)) | (|(stat1_w & regs_q.en1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/scsi_irq_stack_chk.sv
module scsi_irq_stack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en_i,
    input logic [1:0] addr_i,
    input logic [6:0] evt0_i,
    input logic [7:0] rdata_o,
    input logic       busy_o,
    input logic       irq_o,
    input logic [7:0] stat0_w,
    input logic [7:0] pend0_w,
    input logic [2:0] stat1_w,
    input logic [2:0] pend1_w
);
    // R4: an accepted status-zero read empties every bit it saw
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !busy_o && addr_i == 2'd0) |=> ((stat0_w & $past(stat0_w)) == 8'h00));

    // R7: an accepted status read starts the busy period
    assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !busy_o && addr_i[1] == 1'b0) |=> busy_o);

    // R7: a status read while busy leaves the read data alone
    assert_busy_read_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && busy_o && addr_i[1] == 1'b0) |=> $stable(rdata_o));

    // R5: an event hitting a set bit lands in the pending level
    assert_no_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat0_w[6:0] & evt0_i)) |=>
            ((pend0_w[6:0] & $past(stat0_w[6:0] & evt0_i)) == $past(stat0_w[6:0] & evt0_i)));

    // R5: outside busy, nothing pending sits behind an empty status bit
    assert_pend_behind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (((pend0_w & ~stat0_w) == 8'h00) && ((pend1_w & ~stat1_w) == 3'b000)));

    // R8: no request without a recorded condition
    assert_irq_needs_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat0_w == 8'h00 && stat1_w == 3'b000) |-> !irq_o);
endmodule

bind scsi_irq_stack scsi_irq_stack_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .evt0_i  (evt0_i),
    .rdata_o (rdata_o),
    .busy_o  (busy_o),
    .irq_o   (irq_o),
    .stat0_w (stat0_w),
    .pend0_w (pend0_w),
    .stat1_w (stat1_w),
    .pend1_w (pend1_w)
);

// File: tb/scsi_irq_stack_tb_top.sv
`timescale 1ns/1ps
module scsi_irq_stack_tb_top;
    localparam int BUSY = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt0 = '0;
    logic [2:0] evt1 = '0;
    logic       tmode = 1'b0, req = 1'b0, atn = 1'b0;
    logic [2:0] bph = 3'd0, eph = 3'd0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       busy, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scsi_irq_stack #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt0_i(evt0), .evt1_i(evt1),
        .target_mode_i(tmode), .req_i(req), .atn_i(atn),
        .bus_phase_i(bph), .exp_phase_i(eph),
        .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .busy_o(busy), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        rd = 1'b1; addr = a;
        tick(1);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick(1);
        wr = 1'b0;
    endtask

    task automatic req_mismatch();
        tmode = 1'b0; bph = 3'd2; eph = 3'd3; req = 1'b1;
        tick(1);
        req = 1'b0;
        tick(1);
    endtask

    task automatic pulse0(input int i);
        if (i == 7) begin
            req_mismatch();
        end else begin
            evt0[i] = 1'b1;
            tick(1);
            evt0 = '0;
        end
    endtask

    task automatic read_wait(input logic [1:0] a, output logic [7:0] v);
        do_read(a, v);
        tick(BUSY);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 busy", {7'd0, busy}, 8'h00);
        chk("R1 rdata", rdata, 8'h00);
        do_read(2'd2, v); chk("R1 en0", v, 8'h00);
        do_read(2'd3, v); chk("R1 en1", v, 8'h00);
        read_wait(2'd0, v); chk("R1 st0", v, 8'h00);
        read_wait(2'd1, v); chk("R1 st1", v, 8'h00);

        // R2 bit sweep, enables off: read sees it anyway
        for (int i = 0; i < 8; i++) begin
            pulse0(i);
            read_wait(2'd0, v);
            chk($sformatf("R2 st0 bit%0d", i), v, 8'(1 << i));
            read_wait(2'd0, v);
            chk($sformatf("R4 cleared bit%0d", i), v, 8'h00);
        end

        // R3 status one bits and reserved bits
        for (int i = 0; i < 3; i++) begin
            evt1[i] = 1'b1; tick(1); evt1 = '0;
            read_wait(2'd1, v);
            chk($sformatf("R3 st1 bit%0d", i), v, 8'(1 << i));
        end
        do_write(2'd3, 8'hFF);
        do_read(2'd3, v); chk("R3 en1 reserved", v, 8'h07);
        do_write(2'd3, 8'h00);

        // R4 read clears only its own register
        evt0[4] = 1'b1; evt1[1] = 1'b1; tick(1); evt0 = '0; evt1 = '0;
        read_wait(2'd0, v); chk("R4 st0 value", v, 8'h10);
        read_wait(2'd1, v); chk("R4 st1 kept", v, 8'h02);

        // R5 stacked event promoted after busy
        pulse0(3); pulse0(3);
        read_wait(2'd0, v); chk("R5 first read", v, 8'h08);
        read_wait(2'd0, v); chk("R5 promoted", v, 8'h08);
        read_wait(2'd0, v); chk("R5 empty", v, 8'h00);
        // R5 merge: three events give two reads
        pulse0(1); pulse0(1); pulse0(1);
        read_wait(2'd0, v); chk("R5 merge a", v, 8'h02);
        read_wait(2'd0, v); chk("R5 merge b", v, 8'h02);
        read_wait(2'd0, v); chk("R5 merge c", v, 8'h00);

        // R6 event on the clearing read's cycle goes pending
        pulse0(2);
        evt0[2] = 1'b1; evt0[5] = 1'b1;
        do_read(2'd0, v);
        evt0 = '0;
        chk("R6 read value", v, 8'h04);
        tick(BUSY);
        read_wait(2'd0, v); chk("R6 pending and direct", v, 8'h24);
        read_wait(2'd0, v); chk("R6 empty", v, 8'h00);

        // R7 busy length and ignored read while busy
        pulse0(0);
        do_read(2'd0, v); chk("R7 value", v, 8'h01);
        pulse0(5);
        do_read(2'd0, v); chk("R7 ignored read", v, 8'h01);
        tick(BUSY - 3);
        chk("R7 busy still", {7'd0, busy}, 8'h01);
        tick(1);
        chk("R7 busy done", {7'd0, busy}, 8'h00);
        read_wait(2'd0, v); chk("R7 not cleared", v, 8'h20);
        read_wait(2'd0, v);

        // R8 enable x status sweep on bank zero
        for (int j = 0; j < 8; j++) begin
            do_write(2'd2, 8'(1 << j));
            for (int i = 0; i < 8; i++) begin
                pulse0(i);
                chk($sformatf("R8 en%0d st%0d", j, i), {7'd0, irq}, (i == j) ? 8'h01 : 8'h00);
                read_wait(2'd0, v);
                chk($sformatf("R8 low after clear %0d", i), {7'd0, irq}, 8'h00);
            end
        end
        do_write(2'd2, 8'h00);
        for (int j = 0; j < 3; j++) begin
            do_write(2'd3, 8'(1 << j));
            for (int i = 0; i < 3; i++) begin
                evt1[i] = 1'b1; tick(1); evt1 = '0;
                chk($sformatf("R8 en1_%0d st1_%0d", j, i), {7'd0, irq}, (i == j) ? 8'h01 : 8'h00);
                read_wait(2'd1, v);
            end
        end
        do_write(2'd3, 8'h00);

        // R9 writes to status ignored, enable zero full width
        pulse0(6);
        do_write(2'd0, 8'h00); do_write(2'd0, 8'hFF); do_write(2'd1, 8'hFF);
        read_wait(2'd0, v); chk("R9 st0 write ignored", v, 8'h40);
        read_wait(2'd1, v); chk("R9 st1 write ignored", v, 8'h00);
        do_write(2'd2, 8'hA5);
        do_read(2'd2, v); chk("R9 en0 store", v, 8'hA5);
        do_write(2'd2, 8'h00);

        // R10 phase compare rules
        tmode = 1'b0; bph = 3'd3; eph = 3'd3; req = 1'b1; tick(1); req = 1'b0; tick(1);
        read_wait(2'd0, v); chk("R10 match no set", v, 8'h00);
        req_mismatch();
        read_wait(2'd0, v); chk("R10 mismatch sets", v, 8'h80);
        tmode = 1'b1; bph = 3'd1; eph = 3'd6; req = 1'b1; tick(1); req = 1'b0; tick(1);
        read_wait(2'd0, v); chk("R10 target req no effect", v, 8'h00);
        atn = 1'b1; tick(2); atn = 1'b0; tick(1);
        read_wait(2'd0, v); chk("R10 target atn sets", v, 8'h80);
        tmode = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule